// File: doc/BRIEF.md
# Interrupt Status Unit with Deferred Completion

This block holds the interrupt and status state of a bus-controller register file and drives one level-sensitive interrupt line. It keeps an interrupt-reason byte, a status byte (interrupt-pending flag, count-zero flag and a three-bit phase field) and a sequence-step field. Neighbouring logic signals events to it with single-cycle pulses: a plain raise, a lower, a transfer-done event, a bus-reset command and a command completion that carries a status byte.

Software acknowledges an interrupt by reading the reason register through a read-to-clear access. That read returns the old reason, clears it, clears count-zero, loads the sequence step with the command-done code and drops the interrupt. A completion that arrives while an earlier interrupt is still unacknowledged is not lost. The block holds it, with its status byte, in a single slot and replays it automatically on the next acknowledge. Every report and every transfer-done event also sends a one-cycle pulse on `clr_xfer_o`, which tells the neighbouring logic to zero its FIFO flags and transfer counter.

Top module: `irq_status_unit`

## Requirements
- R1: A synchronous reset clears the interrupt output, status, reason, sequence step, reported status byte, the clear pulse and any held completion.
- R2: A raise pulse sets status bit 7 (pending) and asserts `irq_o`. A second raise while pending changes nothing.
- R3: A lower pulse clears status bit 7 and deasserts `irq_o`.
- R4: While `ack_i` is high, `ack_data_o` shows the current reason byte. On the next cycle the reason reads 0.
- R5: An acknowledge clears status bit 4 (count-zero), loads the sequence step with 3'b100, lowers the interrupt and leaves the phase bits [2:0] as they were.
- R6: A completion that arrives while status bit 7 is set changes none of the visible state: status, reason, sequence step and reported status byte stay the same.
- R7: An acknowledge made while a completion is held reports that completion in the next cycle: status 0x93 (pending, count-zero, phase 3'b011), reason 0x10, sequence 0, reported byte equal to the held status, `irq_o` high and one `clr_xfer_o` pulse.
- R8: A completion that arrives with no interrupt pending is reported in the next cycle in the same form as R7, using its own status byte.
- R9: A transfer-done pulse sets count-zero, sets reason to 0x10 and sequence to 0, raises the interrupt and pulses `clr_xfer_o`. The phase bits are left unchanged.
- R10: A bus-reset pulse loads reason 0x80. It raises the interrupt only when `rpt_dis_i` is 0.
- R11: When an acknowledge and a raise fall in the same cycle, the raise wins and `irq_o` stays high, while the other acknowledge effects still apply.
- R12: The hold slot stores one completion. A later completion that arrives while one is held replaces the held status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raise_i | input | 1 | Raise the interrupt |
| lower_i | input | 1 | Lower the interrupt |
| ack_i | input | 1 | Read-to-clear access of the reason register |
| xfer_done_i | input | 1 | Transfer-done event |
| busrst_i | input | 1 | Bus-reset command |
| rpt_dis_i | input | 1 | Configuration bit that suppresses the bus-reset interrupt |
| cmpl_i | input | 1 | Command completion event |
| cmpl_stat_i | input | SW | Status byte of the completion |
| irq_o | output | 1 | Level interrupt |
| ack_data_o | output | 8 | Reason value returned by the acknowledge read |
| reason_o | output | 8 | Interrupt-reason register |
| status_o | output | 8 | Status register |
| seq_o | output | QW | Sequence-step register |
| done_status_o | output | SW | Status byte of the last reported completion |
| clr_xfer_o | output | 1 | Pulse that clears the neighbour FIFO flags and transfer counter |

## Verification
The bench targets the hold-and-replay path. A design that reported a completion at once while an interrupt was pending would overwrite the reason and reported byte before software had read them. A design that forgot to replay would leave `irq_o` low after the acknowledge. A single-slot design that kept the first held byte instead of the newest would report the wrong status. The bench also drives an acknowledge and a raise in the same cycle, where letting the acknowledge win would drop the interrupt. It drives a bus reset with reporting disabled, where an unconditional raise would assert `irq_o`. Finally it resets with a completion held, where a stale slot would replay after the reset.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int SW = 8,
  parameter int QW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raise_i,
  input  logic          lower_i,
  input  logic          ack_i,
  input  logic          xfer_done_i,
  input  logic          busrst_i,
  input  logic          rpt_dis_i,
  input  logic          cmpl_i,
  input  logic [SW-1:0] cmpl_stat_i,
  output logic          irq_o,
  output logic [7:0]    ack_data_o,
  output logic [7:0]    reason_o,
  output logic [7:0]    status_o,
  output logic [QW-1:0] seq_o,
  output logic [SW-1:0] done_status_o,
  output logic          clr_xfer_o
);
  localparam logic [7:0]    R_BUS  = 8'h10;
  localparam logic [7:0]    R_RST  = 8'h80;
  localparam logic [2:0]    PH_ST  = 3'b011;
  localparam logic [QW-1:0] SEQ_CD = QW'(4);

  logic          pend_q, pend_n, tcz_q, tcz_n, defer_q, defer_n, clr_q;
  logic [2:0]    ph_q, ph_n;
  logic [7:0]    reason_q, reason_n;
  logic [QW-1:0] seq_q, seq_n;
  logic [SW-1:0] defer_stat_q, defer_stat_n, done_q, done_n;

  logic replay, hold_new, rep_now, report, done_evt;
  logic [SW-1:0] rep_stat;

  assign replay   = ack_i & defer_q;
  assign hold_new = cmpl_i & (pend_q | replay);
  assign rep_now  = cmpl_i & ~hold_new;
  assign report   = replay | rep_now;
  assign rep_stat = replay ? defer_stat_q : cmpl_stat_i;
  assign done_evt = report | xfer_done_i;

  always_comb begin
    pend_n = pend_q; tcz_n = tcz_q; ph_n = ph_q;
    reason_n = reason_q; seq_n = seq_q;
    if (ack_i) begin
      reason_n = '0; tcz_n = 1'b0; seq_n = SEQ_CD; pend_n = 1'b0;
    end
    if (lower_i) pend_n = 1'b0;
    if (report) begin
      ph_n = PH_ST; tcz_n = 1'b0;
    end
    if (done_evt) begin
      tcz_n = 1'b1; reason_n = R_BUS; seq_n = '0; pend_n = 1'b1;
    end
    if (busrst_i) begin
      reason_n = R_RST;
      if (!rpt_dis_i) pend_n = 1'b1;
    end
    if (raise_i) pend_n = 1'b1;
  end

  always_comb begin
    defer_n = defer_q; defer_stat_n = defer_stat_q;
    if (hold_new) begin
      defer_n = 1'b1; defer_stat_n = cmpl_stat_i;
    end else if (replay) begin
      defer_n = 1'b0;
    end
  end

  assign done_n = report ? rep_stat : done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0; tcz_q <= 1'b0; ph_q <= '0; reason_q <= '0; seq_q <= '0;
      defer_q <= 1'b0; defer_stat_q <= '0; done_q <= '0; clr_q <= 1'b0;
    end else begin
      pend_q <= pend_n; tcz_q <= tcz_n; ph_q <= ph_n; reason_q <= reason_n;
      seq_q <= seq_n; defer_q <= defer_n; defer_stat_q <= defer_stat_n;
      done_q <= done_n; clr_q <= done_evt;
    end
  end

  assign irq_o         = pend_q;
  assign ack_data_o    = reason_q;
  assign reason_o      = reason_q;
  assign status_o      = {pend_q, 2'b00, tcz_q, 1'b0, ph_q};
  assign seq_o         = seq_q;
  assign done_status_o = done_q;
  assign clr_xfer_o    = clr_q;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int SW = 8,
  parameter int QW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          raise_i,
  input logic          lower_i,
  input logic          ack_i,
  input logic          xfer_done_i,
  input logic          busrst_i,
  input logic          rpt_dis_i,
  input logic          cmpl_i,
  input logic [SW-1:0] cmpl_stat_i,
  input logic          irq_o,
  input logic [7:0]    reason_o,
  input logic [7:0]    status_o,
  input logic [QW-1:0] seq_o,
  input logic [SW-1:0] done_status_o,
  input logic          clr_xfer_o,
  input logic          defer_q,
  input logic [SW-1:0] defer_stat_q
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && reason_o == 8'h00 && status_o == 8'h00 && !defer_q && !clr_xfer_o));

  assert_raise_sets_R2: assert property (@(posedge clk) disable iff (rst)
    raise_i |=> (irq_o && status_o[7]));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !defer_q && !raise_i && !xfer_done_i && !cmpl_i && !busrst_i)
    |=> (!irq_o && reason_o == 8'h00 && seq_o == QW'(4) && !status_o[4]));

  assert_hold_when_pending_R6: assert property (@(posedge clk) disable iff (rst)
    (cmpl_i && irq_o && !ack_i) |=> (defer_q && defer_stat_q == $past(cmpl_stat_i)
                                     && done_status_o == $past(done_status_o)));

  assert_replay_on_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_i && defer_q && !cmpl_i && !busrst_i)
    |=> (irq_o && reason_o == 8'h10 && !defer_q && done_status_o == $past(defer_stat_q)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_done_i |=> (clr_xfer_o && status_o[4]));

  assert_busrst_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (busrst_i && rpt_dis_i && !irq_o && !raise_i && !xfer_done_i && !cmpl_i)
    |=> (!irq_o && reason_o == 8'h80));

  assert_raise_beats_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (ack_i && raise_i) |=> irq_o);
endmodule

bind irq_status_unit irq_status_unit_chk #(.SW(SW), .QW(QW)) u_chk (
  .clk(clk), .rst(rst), .raise_i(raise_i), .lower_i(lower_i), .ack_i(ack_i),
  .xfer_done_i(xfer_done_i), .busrst_i(busrst_i), .rpt_dis_i(rpt_dis_i),
  .cmpl_i(cmpl_i), .cmpl_stat_i(cmpl_stat_i), .irq_o(irq_o), .reason_o(reason_o),
  .status_o(status_o), .seq_o(seq_o), .done_status_o(done_status_o),
  .clr_xfer_o(clr_xfer_o), .defer_q(defer_q), .defer_stat_q(defer_stat_q)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic raise_i = 0, lower_i = 0, ack_i = 0, xfer_done_i = 0, busrst_i = 0, rpt_dis_i = 0, cmpl_i = 0;
  logic [7:0] cmpl_stat_i = '0;
  logic irq_o, clr_xfer_o;
  logic [7:0] ack_data_o, reason_o, status_o, done_status_o;
  logic [2:0] seq_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit u_dut (
    .clk(clk), .rst(rst), .raise_i(raise_i), .lower_i(lower_i), .ack_i(ack_i),
    .xfer_done_i(xfer_done_i), .busrst_i(busrst_i), .rpt_dis_i(rpt_dis_i),
    .cmpl_i(cmpl_i), .cmpl_stat_i(cmpl_stat_i), .irq_o(irq_o), .ack_data_o(ack_data_o),
    .reason_o(reason_o), .status_o(status_o), .seq_o(seq_o),
    .done_status_o(done_status_o), .clr_xfer_o(clr_xfer_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    raise_i = 0; lower_i = 0; ack_i = 0; xfer_done_i = 0; busrst_i = 0; cmpl_i = 0;
  endtask

  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1 irq", irq_o, 0); chk("R1 status", status_o, 0);
    chk("R1 reason", reason_o, 0); chk("R1 seq", seq_o, 0);
    chk("R1 done", done_status_o, 0); chk("R1 clr", clr_xfer_o, 0);
  endtask

  task automatic t_raise_lower();
    raise_i = 1; step();
    chk("R2 irq", irq_o, 1); chk("R2 status", status_o, 8'h80);
    raise_i = 1; step();
    chk("R2 second raise", status_o, 8'h80);
    lower_i = 1; step();
    chk("R3 irq", irq_o, 0); chk("R3 status", status_o, 8'h00);
  endtask

  task automatic t_xfer_ack();
    xfer_done_i = 1; step();
    chk("R9 status", status_o, 8'h90); chk("R9 reason", reason_o, 8'h10);
    chk("R9 seq", seq_o, 0); chk("R9 clr", clr_xfer_o, 1); chk("R9 irq", irq_o, 1);
    step();
    chk("R9 clr single", clr_xfer_o, 0);
    ack_i = 1; #1;
    chk("R4 ack data", ack_data_o, 8'h10);
    step();
    chk("R4 reason cleared", reason_o, 0); chk("R5 status", status_o, 8'h00);
    chk("R5 seq", seq_o, 3'b100); chk("R5 irq", irq_o, 0);
  endtask

  task automatic t_cmpl_now();
    cmpl_stat_i = 8'h02; cmpl_i = 1; step();
    chk("R8 status", status_o, 8'h93); chk("R8 reason", reason_o, 8'h10);
    chk("R8 seq", seq_o, 0); chk("R8 done", done_status_o, 8'h02); chk("R8 irq", irq_o, 1);
  endtask

  task automatic t_defer();
    cmpl_stat_i = 8'h5A; cmpl_i = 1; step();
    chk("R6 status", status_o, 8'h93); chk("R6 done", done_status_o, 8'h02);
    chk("R6 seq", seq_o, 0); chk("R6 reason", reason_o, 8'h10);
    cmpl_stat_i = 8'h3C; cmpl_i = 1; step();
    ack_i = 1; #1;
    chk("R4 ack data", ack_data_o, 8'h10);
    step();
    chk("R7 status", status_o, 8'h93); chk("R7 reason", reason_o, 8'h10);
    chk("R7 seq", seq_o, 0); chk("R7 irq", irq_o, 1); chk("R7 clr", clr_xfer_o, 1);
    chk("R12 newest held byte", done_status_o, 8'h3C);
    ack_i = 1; step();
    chk("R5 phase kept", status_o, 8'h03); chk("R7 no second replay", irq_o, 0);
    chk("R5 seq", seq_o, 3'b100);
  endtask

  task automatic t_busrst();
    rpt_dis_i = 1; busrst_i = 1; step();
    chk("R10 reason dis", reason_o, 8'h80); chk("R10 irq dis", irq_o, 0);
    ack_i = 1; step();
    rpt_dis_i = 0; busrst_i = 1; step();
    chk("R10 reason en", reason_o, 8'h80); chk("R10 irq en", irq_o, 1);
    ack_i = 1; step();
    chk("R10 ack clears", irq_o, 0);
  endtask

  task automatic t_ack_raise();
    raise_i = 1; step();
    ack_i = 1; raise_i = 1; step();
    chk("R11 irq", irq_o, 1); chk("R11 status", status_o, 8'h83);
    chk("R11 seq", seq_o, 3'b100);
    ack_i = 1; step();
    chk("R11 later ack", irq_o, 0);
  endtask

  task automatic t_reset_held();
    raise_i = 1; step();
    cmpl_stat_i = 8'hA5; cmpl_i = 1; step();
    rst = 1; step(); rst = 0;
    t_reset();
    ack_i = 1; step();
    chk("R1 held dropped irq", irq_o, 0); chk("R1 held dropped done", done_status_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_raise_lower();
    t_xfer_ack();
    t_cmpl_now();
    t_defer();
    t_busrst();
    t_ack_raise();
    t_reset_held();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule